// File: doc/BRIEF.md
# Interval Timer Channel

This block is one 16-bit down-counting channel of a legacy interval timer. A count-enable strobe marks each timebase period; the strobe normally fires at a fixed rate of 1.193182 MHz, derived from the system clock. A gate input qualifies or triggers counting. A three-bit operating mode field and a decimal-select bit are written with a mode strobe, and a start value is written with a load strobe. The channel drives one output pin whose waveform depends on the mode: a one-shot level, a retriggerable or software-started strobe, a rate pulse, or a square wave.

The count can be read in two ways. The live counter value is always visible. A latch strobe takes a snapshot of the count that stays in place for readback. A status bit shows whether a start value has reached the counter since the last mode write. Counting can run in plain binary or in four-digit decimal. A start value of zero gives the longest period. Bus decoding, port addressing and interrupt delivery are left to the surrounding logic.

Top module: `pit_channel`

## Requirements
- R1: After reset the output pin is 1, the count and the snapshot are 0, and the loaded status is 0.
- R2: Mode field 0 (one-shot level): a mode write drives the pin low. The strobe after a load moves the start value into the counter. Further strobes decrement only while gate is 1. The pin goes to 1 on the strobe that brings the count from 1 to 0 and stays there.
- R3: Mode field 1 (triggered one-shot): the pin stays 1 until a rising gate edge is followed by a strobe. That strobe loads the counter and drives the pin low. Counting then continues whatever the gate does, and the pin returns to 1 when the count reaches 0.
- R4: Mode field 2 (rate): on the strobe that makes the count 1 the pin drops to 0. On the next strobe the counter reloads and the pin returns to 1. A low gate stops counting and forces the pin to 1 on the next clock. A rising gate restarts the count from the start value on the next strobe.
- R5: Mode field 3 (square wave): the counter steps by 2 and only even values appear. For an even start value N the pin is high for N/2 strobes and low for N/2. For an odd N it is high for (N+1)/2 and low for (N-1)/2.
- R6: Mode field 4 (software strobe): the pin stays 1. On the strobe that takes the count from 1 to 0 it drops to 0 for exactly one strobe. There is no reload and no second pulse. Counting requires gate = 1.
- R7: Mode field 5 (hardware strobe): a rising gate edge followed by a strobe loads the counter. Counting then ignores the gate. The pin pulses to 0 for one strobe at the 1-to-0 step, with no reload.
- R8: With the decimal-select bit = 1, each digit nibble counts 9 down to 0 and borrows from the next nibble, so 0x0100 steps to 0x0099.
- R9: A start value of 0 acts as the maximum count: 65536 strobes in binary and 10000 in decimal until the count returns to 0.
- R10: Mode field values 6 and 7 behave exactly as 2 and 3.
- R11: Loaded status clears on a mode write and sets on the strobe that moves a start value into the counter.
- R12: A latch strobe copies the current count into the snapshot, which then holds while counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Timebase strobe, one counting step per asserted clock |
| gate | input | 1 | Gate level; its rising edge is captured as a trigger |
| mode_wr | input | 1 | Writes mode_sel and bcd_sel; clears loaded status |
| mode_sel | input | 3 | Operating mode field, 0 to 7 |
| bcd_sel | input | 1 | 1 selects four-digit decimal counting |
| load_stb | input | 1 | Writes load_val as the start value |
| load_val | input | 16 | Start value |
| latch_stb | input | 1 | Copies the count into the snapshot |
| out_pin | output | 1 | Channel output |
| count | output | 16 | Live counter value |
| latched_count | output | 16 | Count snapshot |
| count_loaded | output | 1 | Start value has reached the counter |

## Verification
The bench uses the default of four digits, so the counter is 16 bits wide. It holds the strobe high for long runs, one strobe per clock. This lets it cover both zero-start full periods, 65536 steps in binary and 10000 in decimal, and check the exact strobe on which the pin changes. Small start values of 3 to 6 make every pin transition of the rate, square-wave and strobe modes visible within a few steps. This includes odd and even halving in the square-wave mode and the one-strobe width of the strobe pulses.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    PM_ONESHOT_SW = 3'd0,
    PM_ONESHOT_HW = 3'd1,
    PM_RATE       = 3'd2,
    PM_SQUARE     = 3'd3,
    PM_STROBE_SW  = 3'd4,
    PM_STROBE_HW  = 3'd5
  } pit_mode_e;

  // Field values 6 and 7 fold onto the periodic modes.
  function automatic pit_mode_e pit_norm_mode(input logic [2:0] field);
    case (field)
      3'd6:    return PM_RATE;
      3'd7:    return PM_SQUARE;
      default: return pit_mode_e'(field);
    endcase
  endfunction

  function automatic logic pit_mode_inits_low(input logic [2:0] field);
    return field == 3'd0;
  endfunction

endpackage

// File: rtl/pit_dec1.sv
// Decrement by one, binary or packed decimal, selected at run time.
module pit_dec1 #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  input  logic                bcd,
  output logic [4*DIGITS-1:0] res
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS-1:0] borrow;
  logic [W-1:0]      bcd_res;

  assign borrow[0] = 1'b1;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [3:0] d;
      assign d = val[4*i +: 4];
      assign bcd_res[4*i +: 4] = borrow[i] ? ((d == 4'd0) ? 4'd9 : d - 4'd1) : d;
      if (i < DIGITS - 1) begin : g_chain
        assign borrow[i+1] = borrow[i] & (d == 4'd0);
      end
    end
  endgenerate

  assign res = bcd ? bcd_res : (val - W'(1));

endmodule

// File: rtl/pit_trigger.sv
// Captures a rising gate edge and holds it until the next timebase strobe.
module pit_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic tick,
  input  logic mode_wr,
  output logic trig_hit
);
  logic gate_q;
  logic trig_q;
  logic gate_rise;

  assign gate_rise = gate & ~gate_q;
  assign trig_hit  = trig_q | gate_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (mode_wr || tick) trig_q <= 1'b0;
      else if (gate_rise)  trig_q <= 1'b1;
    end
  end

  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_rise && !mode_wr && !tick) |=> trig_hit); // R3

endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                gate,
  input  logic                mode_wr,
  input  logic [2:0]          mode_field,
  input  logic                bcd_field,
  input  logic                load_stb,
  input  logic [4*DIGITS-1:0] load_val,
  input  logic                trig_hit,
  output logic [4*DIGITS-1:0] cnt_o,
  output logic                out_o,
  output logic                loaded_o
);
  localparam int           W   = 4 * DIGITS;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  pit_mode_e    mode_q;
  logic         bcd_q;
  logic [W-1:0] cnt_q, reload_q;
  logic         out_q, loaded_q, pend_q, valid_q, armed_q;

  // Step results: one and two counts below the present value.
  logic [W-1:0] dec1, dec2;

  pit_dec1 #(.DIGITS(DIGITS)) u_dec_a (.val(cnt_q), .bcd(bcd_q), .res(dec1));
  pit_dec1 #(.DIGITS(DIGITS)) u_dec_b (.val(dec1),  .bcd(bcd_q), .res(dec2));

  // Named internal events.
  logic [W-1:0] reload_even;
  logic at_zero, at_one, at_two;
  logic hit_zero, is_periodic, is_strobe;
  logic first_load, restart, trig_start, sq_term;

  assign reload_even = reload_q & ~ONE;
  assign at_zero     = (cnt_q == '0);
  assign at_one      = (cnt_q == ONE);
  assign at_two      = (cnt_q == TWO);
  assign hit_zero    = armed_q && at_one;
  assign is_periodic = (mode_q == PM_RATE) || (mode_q == PM_SQUARE);
  assign is_strobe   = (mode_q == PM_STROBE_SW) || (mode_q == PM_STROBE_HW);
  assign first_load  = pend_q && !loaded_q;
  assign restart     = trig_hit && loaded_q;
  assign trig_start  = trig_hit && valid_q;
  // Odd start value: the high half runs one step further, down through zero.
  assign sq_term     = (out_q && reload_q[0]) ? at_zero : at_two;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= PM_ONESHOT_SW;
      bcd_q    <= 1'b0;
      cnt_q    <= '0;
      reload_q <= '0;
      out_q    <= 1'b1;
      loaded_q <= 1'b0;
      pend_q   <= 1'b0;
      valid_q  <= 1'b0;
      armed_q  <= 1'b0;
    end else if (mode_wr) begin
      mode_q   <= pit_norm_mode(mode_field);
      bcd_q    <= bcd_field;
      loaded_q <= 1'b0;
      pend_q   <= 1'b0;
      valid_q  <= 1'b0;
      armed_q  <= 1'b0;
      out_q    <= !pit_mode_inits_low(mode_field);
    end else begin
      if (load_stb) begin
        reload_q <= load_val;
        pend_q   <= 1'b1;
        valid_q  <= 1'b1;
      end
      if (is_periodic && !gate) out_q <= 1'b1;
      if (tick) begin
        case (mode_q)
          PM_ONESHOT_SW, PM_STROBE_SW: begin
            if (pend_q) begin
              cnt_q    <= reload_q;
              loaded_q <= 1'b1;
              armed_q  <= 1'b1;
              pend_q   <= load_stb;
              out_q    <= (mode_q == PM_STROBE_SW);
            end else begin
              if (is_strobe && !out_q) out_q <= 1'b1;
              if (loaded_q && gate) begin
                cnt_q <= dec1;
                if (hit_zero) begin
                  armed_q <= 1'b0;
                  out_q   <= (mode_q == PM_ONESHOT_SW);
                end
              end
            end
          end
          PM_ONESHOT_HW, PM_STROBE_HW: begin
            if (trig_start) begin
              cnt_q    <= reload_q;
              loaded_q <= 1'b1;
              armed_q  <= 1'b1;
              pend_q   <= load_stb;
              out_q    <= (mode_q == PM_STROBE_HW);
            end else begin
              if (is_strobe && !out_q) out_q <= 1'b1;
              if (loaded_q) begin
                cnt_q <= dec1;
                if (hit_zero) begin
                  armed_q <= 1'b0;
                  out_q   <= (mode_q == PM_ONESHOT_HW);
                end
              end
            end
          end
          PM_RATE: begin
            if (first_load || restart) begin
              cnt_q    <= reload_q;
              loaded_q <= 1'b1;
              pend_q   <= load_stb;
              out_q    <= 1'b1;
            end else if (loaded_q && gate) begin
              if (at_one) begin
                cnt_q <= reload_q;
                out_q <= 1'b1;
              end else begin
                cnt_q <= dec1;
                if (at_two) out_q <= 1'b0;
              end
            end
          end
          PM_SQUARE: begin
            if (first_load || restart) begin
              cnt_q    <= reload_even;
              loaded_q <= 1'b1;
              pend_q   <= load_stb;
              out_q    <= 1'b1;
            end else if (loaded_q && gate) begin
              if (sq_term) begin
                cnt_q <= reload_even;
                out_q <= ~out_q;
              end else begin
                cnt_q <= dec2;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign out_o    = out_q;
  assign loaded_o = loaded_q;

  AST_LEVEL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_ONESHOT_SW && out_q && !mode_wr && !pend_q) |=> out_q); // R2

  AST_GATE_LOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_periodic && !gate && !mode_wr) |=> out_q); // R4

  AST_SQUARE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SQUARE && loaded_q) |-> !cnt_q[0]); // R5

  AST_PULSE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_strobe && !out_q && tick && !mode_wr) |=> out_q); // R6 R7

  AST_MODE_CLEARS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !loaded_q); // R11

endmodule

// File: rtl/pit_snap.sv
// Count snapshot for readback.
module pit_snap #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                latch_stb,
  input  logic [4*DIGITS-1:0] cnt,
  output logic [4*DIGITS-1:0] snap
);
  always_ff @(posedge clk) begin
    if (!rst_n)         snap <= '0;
    else if (latch_stb) snap <= cnt;
  end

  AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(snap)); // R12

endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         gate,
  input  logic         mode_wr,
  input  logic [2:0]   mode_sel,
  input  logic         bcd_sel,
  input  logic         load_stb,
  input  logic [W-1:0] load_val,
  input  logic         latch_stb,
  output logic         out_pin,
  output logic [W-1:0] count,
  output logic [W-1:0] latched_count,
  output logic         count_loaded
);
  logic trig_hit;

  pit_trigger u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate     (gate),
    .tick     (cnt_en),
    .mode_wr  (mode_wr),
    .trig_hit (trig_hit)
  );

  pit_core #(.DIGITS(DIGITS)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (cnt_en),
    .gate       (gate),
    .mode_wr    (mode_wr),
    .mode_field (mode_sel),
    .bcd_field  (bcd_sel),
    .load_stb   (load_stb),
    .load_val   (load_val),
    .trig_hit   (trig_hit),
    .cnt_o      (count),
    .out_o      (out_pin),
    .loaded_o   (count_loaded)
  );

  pit_snap #(.DIGITS(DIGITS)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_stb (latch_stb),
    .cnt       (count),
    .snap      (latched_count)
  );

endmodule

// File: tb/pit_channel_tb.sv
`timescale 1ns/1ps
module pit_channel_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, gate = 1'b0, mode_wr = 1'b0, bcd_sel = 1'b0;
  logic load_stb = 1'b0, latch_stb = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic [W-1:0] load_val = '0;
  logic out_pin, count_loaded;
  logic [W-1:0] count, latched_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pit_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .mode_wr(mode_wr),
    .mode_sel(mode_sel), .bcd_sel(bcd_sel), .load_stb(load_stb), .load_val(load_val),
    .latch_stb(latch_stb), .out_pin(out_pin), .count(count),
    .latched_count(latched_count), .count_loaded(count_loaded)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m, input logic b);
    @(negedge clk);
    mode_sel = m; bcd_sel = b; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic load(input logic [W-1:0] v);
    @(negedge clk);
    load_val = v; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk);
    gate = g;
    idle();
  endtask

  task automatic t_reset();
    chk("R1 out", out_pin, 1);
    chk("R1 count", count, 0);
    chk("R1 snapshot", latched_count, 0);
    chk("R1 loaded", count_loaded, 0);
  endtask

  task automatic t_mode0();
    set_gate(1);
    set_mode(3'd0, 0);
    chk("R2 low after mode write", out_pin, 0);
    load(16'd5);
    tick_n(1);
    chk("R2 loaded count", count, 5);
    chk("R2 low while counting", out_pin, 0);
    tick_n(4);
    chk("R2 count at 1", count, 1);
    chk("R2 still low at 1", out_pin, 0);
    tick_n(1);
    chk("R2 count 0", count, 0);
    chk("R2 high at 0", out_pin, 1);
    load(16'd3);
    tick_n(1);
    chk("R2 reload drives low", out_pin, 0);
    set_gate(0);
    tick_n(2);
    chk("R2 gate low holds count", count, 3);
    set_gate(1);
    tick_n(3);
    chk("R2 resumes to 0", count, 0);
    chk("R2 high after resume", out_pin, 1);
    tick_n(4);
    chk("R2 stays high", out_pin, 1);
  endtask

  task automatic t_mode1();
    set_gate(0);
    set_mode(3'd1, 0);
    chk("R3 high after mode write", out_pin, 1);
    load(16'd4);
    tick_n(2);
    chk("R3 no start without edge", count_loaded, 0);
    chk("R3 high before edge", out_pin, 1);
    set_gate(1);
    tick_n(1);
    chk("R3 count after trigger", count, 4);
    chk("R3 low while counting", out_pin, 0);
    set_gate(0);
    tick_n(3);
    chk("R3 counts with gate low", count, 1);
    chk("R3 low at 1", out_pin, 0);
    tick_n(1);
    chk("R3 high at 0", out_pin, 1);
  endtask

  task automatic t_mode2();
    set_gate(1);
    set_mode(3'd2, 0);
    load(16'd3);
    tick_n(1);
    chk("R4 load", count, 3);
    chk("R4 out high", out_pin, 1);
    tick_n(1);
    chk("R4 out high at 2", out_pin, 1);
    tick_n(1);
    chk("R4 count 1", count, 1);
    chk("R4 low at 1", out_pin, 0);
    tick_n(1);
    chk("R4 reload", count, 3);
    chk("R4 high after reload", out_pin, 1);
    tick_n(2);
    chk("R4 low again", out_pin, 0);
    set_gate(0);
    chk("R4 gate low forces high", out_pin, 1);
    tick_n(2);
    chk("R4 gate low halts", count, 1);
    set_gate(1);
    tick_n(1);
    chk("R4 gate rise restarts", count, 3);
  endtask

  task automatic sq_run(input int n);
    int ones = 0;
    int fall = 0;
    int odd_seen = 0;
    set_gate(1);
    set_mode(3'd3, 0);
    load(W'(n));
    tick_n(1);
    chk("R5 even load", count, n & ~1);
    for (int k = 1; k <= n; k++) begin
      tick_n(1);
      if (count[0]) odd_seen++;
      if (out_pin) ones++;
      else if (fall == 0) fall = k;
    end
    chk("R5 high steps per period", ones, (n + 1) / 2);
    chk("R5 fall step", fall, (n + 1) / 2);
    chk("R5 only even values", odd_seen, 0);
  endtask

  task automatic t_mode3();
    sq_run(6);
    sq_run(5);
  endtask

  task automatic t_mode4();
    set_gate(1);
    set_mode(3'd4, 0);
    chk("R6 high after mode write", out_pin, 1);
    load(16'd3);
    tick_n(1);
    chk("R6 load", count, 3);
    tick_n(2);
    chk("R6 high at 1", out_pin, 1);
    tick_n(1);
    chk("R6 pulse low", out_pin, 0);
    tick_n(1);
    chk("R6 pulse one step", out_pin, 1);
    chk("R6 no reload", count, 16'hFFFF);
    tick_n(3);
    chk("R6 no second pulse", out_pin, 1);
    load(16'd2);
    tick_n(1);
    set_gate(0);
    tick_n(2);
    chk("R6 gate low holds", count, 2);
  endtask

  task automatic t_mode5();
    set_gate(0);
    set_mode(3'd5, 0);
    load(16'd3);
    tick_n(2);
    chk("R7 waits for edge", count_loaded, 0);
    set_gate(1);
    tick_n(1);
    chk("R7 trigger loads", count, 3);
    chk("R7 high after trigger", out_pin, 1);
    set_gate(0);
    tick_n(2);
    chk("R7 counts with gate low", count, 1);
    tick_n(1);
    chk("R7 pulse low", out_pin, 0);
    tick_n(1);
    chk("R7 pulse one step", out_pin, 1);
    chk("R7 no reload", count, 16'hFFFF);
  endtask

  task automatic t_bcd();
    set_gate(1);
    set_mode(3'd0, 1);
    load(16'h0102);
    tick_n(3);
    chk("R8 decimal step", count, 16'h0100);
    tick_n(1);
    chk("R8 decimal borrow", count, 16'h0099);
    tick_n(99);
    chk("R8 decimal reaches 0", count, 16'h0000);
    chk("R8 out high", out_pin, 1);
    set_mode(3'd3, 1);
    load(16'h0010);
    tick_n(2);
    chk("R8 decimal step by two", count, 16'h0008);
  endtask

  task automatic t_zero();
    set_gate(1);
    set_mode(3'd0, 0);
    load(16'h0000);
    tick_n(2);
    chk("R9 binary wrap", count, 16'hFFFF);
    tick_n(65534);
    chk("R9 binary at 1", count, 1);
    chk("R9 binary low", out_pin, 0);
    tick_n(1);
    chk("R9 binary 65536 steps", out_pin, 1);
    set_mode(3'd0, 1);
    load(16'h0000);
    tick_n(2);
    chk("R9 decimal wrap", count, 16'h9999);
    tick_n(9998);
    chk("R9 decimal at 1", count, 1);
    chk("R9 decimal low", out_pin, 0);
    tick_n(1);
    chk("R9 decimal 10000 steps", out_pin, 1);
  endtask

  task automatic t_alias();
    set_gate(1);
    set_mode(3'd6, 0);
    load(16'd3);
    tick_n(3);
    chk("R10 field 6 low at 1", out_pin, 0);
    tick_n(1);
    chk("R10 field 6 reload", count, 3);
    set_mode(3'd7, 0);
    load(16'd4);
    tick_n(2);
    chk("R10 field 7 steps by two", count, 2);
    tick_n(1);
    chk("R10 field 7 toggles", out_pin, 0);
    chk("R10 field 7 reload", count, 4);
  endtask

  task automatic t_loaded();
    set_gate(1);
    set_mode(3'd2, 0);
    chk("R11 cleared by mode write", count_loaded, 0);
    load(16'd7);
    chk("R11 clear before transfer", count_loaded, 0);
    tick_n(1);
    chk("R11 set on transfer", count_loaded, 1);
  endtask

  task automatic t_latch();
    set_gate(1);
    set_mode(3'd2, 0);
    load(16'd5);
    tick_n(1);
    @(negedge clk); latch_stb = 1'b1;
    @(negedge clk); latch_stb = 1'b0;
    chk("R12 snapshot", latched_count, 5);
    tick_n(2);
    chk("R12 count moves", count, 3);
    chk("R12 snapshot holds", latched_count, 5);
    @(negedge clk); latch_stb = 1'b1;
    @(negedge clk); latch_stb = 1'b0;
    chk("R12 new snapshot", latched_count, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_bcd();
    t_zero();
    t_alias();
    t_loaded();
    t_latch();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule